// File: doc/BRIEF.md
# Cascadable Serial Configuration ROM

This block models a serial bit store that feeds an FPGA configuration input with one bit per clock. An internal address counter selects the bit on the serial output. Each rising clock edge moves the counter on by one while the device is enabled and not held in reset. A single combined pin acts as reset and as output enable. A parameter sets the level of that pin that means "reset".

Several devices can share the clock and data lines and form a chain. The cascade output of one device drives the active-low chip enable of the next. When a device has presented its last bit, it stops driving and asserts its cascade output, and the next device continues the stream. The tri-state data pin is modelled as a data bit plus a drive-enable bit. A synchronous load port fills the array.

Top module: `serial_cfg_rom`

## Requirements
- R1: When the combined pin is in its reset level, a clock edge returns the address to the first bit (address 0) and clears the cascade output. After release, address 0's bit is on `sdo`.
- R2: On each clock edge with `ce_n` low, the pin in its enable level and the address below the last one, the address advances by one, and that address's bit appears on `sdo`.
- R3: With `RST_ACTIVE_HIGH` = 1 the pin resets when high and enables when low. With `RST_ACTIVE_HIGH` = 0 the opposite levels apply.
- R4: While the pin is in its reset level, `sdo_en` is 0 and `sdo` is 0 in the same cycle, without waiting for a clock edge.
- R5: While `ce_n` is high (standby), `sdo_en` is 0 whatever the combined pin does, and the address does not change. On return to enable, the same bit is presented again.
- R6: The first enabled edge with the last address presented sets terminal count. Then `ceo_n` goes low, `sdo_en` goes 0, and the address stays frozen while the device remains enabled.
- R7: A clock edge with `ce_n` high, or with the pin in its reset level, returns `ceo_n` to 1.
- R8: In a chain where `ceo_n` drives the next device's `ce_n`, at most one device has `sdo_en` set in any cycle. The next device presents its own bit 0 in the cycle after the first device reaches terminal count.
- R9: A clock edge with `ld_we` high stores `ld_bit` at `ld_addr`. Bit k of the contents is read out at address k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared configuration clock |
| ce_n | input | 1 | Chip enable, active low; high selects standby |
| rst_oe | input | 1 | Combined reset / output enable, level set by RST_ACTIVE_HIGH |
| ld_we | input | 1 | Load port write enable |
| ld_addr | input | ADDR_W | Load port bit address |
| ld_bit | input | 1 | Load port data bit |
| sdo | output | 1 | Serial data value (0 when not driven) |
| sdo_en | output | 1 | Serial data drive enable; 0 means high impedance |
| ceo_n | output | 1 | Cascade enable to next device, active low |

## Verification
The bench builds a chain of two devices with active-low reset, of depths 16 and 8. The shallow arrays let both terminal counts and the hand-over onto the shared data line be reached in a few dozen cycles. A third, standalone device of depth 8 uses active-high reset, so both settings of the polarity parameter are exercised against the same stimulus sequence. Distinct bit patterns in each array show whether a stray bit comes from the wrong device or the wrong address.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;

    typedef enum logic [1:0] {
        CM_CLEAR,   // reset level on the combined pin
        CM_IDLE,    // standby: hold address, drop terminal count
        CM_STEP,    // advance to next bit
        CM_PARK     // terminal count reached, hold
    } ctr_mode_e;

    // Output-enable sense of the combined pin for a given reset polarity.
    function automatic logic pin_enables(input logic pin, input logic rst_high);
        return pin ^ rst_high;
    endfunction

endpackage

// File: rtl/cfg_bit_array.sv
module cfg_bit_array #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wbit,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rbit
);

    logic [DEPTH-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (we && (int'(waddr) < DEPTH)) begin
            bits_d[waddr] = wbit;
        end
    end

    always_ff @(posedge clk) begin
        bits_q <= bits_d;
    end

    assign rbit = (int'(raddr) < DEPTH) ? bits_q[raddr] : 1'b0;

    // R9: a written bit is held at its address after the edge
    a_r9_write_lands: assert property (@(posedge clk)
        (we && (int'(waddr) < DEPTH)) |=> (bits_q[$past(waddr)] == $past(wbit)));

endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr
    import cfg_rom_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_act,
    input  logic              ce_n,
    output logic [ADDR_W-1:0] addr,
    output logic              tc
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              tc;
    } ctr_t;

    ctr_t      st_d, st_q;
    ctr_mode_e mode;

    always_comb begin
        st_d = st_q;
        if (rst_act) begin
            mode = CM_CLEAR;
        end else if (ce_n) begin
            mode = CM_IDLE;
        end else if (st_q.tc || (st_q.addr == LAST)) begin
            mode = CM_PARK;
        end else begin
            mode = CM_STEP;
        end
        case (mode)
            CM_CLEAR: begin
                st_d.addr = '0;
                st_d.tc   = 1'b0;
            end
            CM_IDLE:  st_d.tc = 1'b0;
            CM_STEP:  st_d.addr = st_q.addr + 1'b1;
            CM_PARK:  st_d.tc = 1'b1;
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr = st_q.addr;
    assign tc   = st_q.tc;

    // R1: a reset-level edge returns to the first bit and clears terminal count
    a_r1_reset_clears: assert property (@(posedge clk)
        rst_act |=> (st_q.addr == '0) && !st_q.tc);

    // R2: an enabled edge below the last address steps by one
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst_act)
        (!ce_n && !st_q.tc && (st_q.addr != LAST)) |=> (st_q.addr == $past(st_q.addr) + 1'b1));

    // R5: standby freezes the address
    a_r5_standby_holds: assert property (@(posedge clk) disable iff (rst_act)
        ce_n |=> $stable(st_q.addr));

    // R6: terminal count is sticky while enabled and freezes the address
    a_r6_park_at_end: assert property (@(posedge clk) disable iff (rst_act)
        (st_q.tc && !ce_n) |=> (st_q.tc && $stable(st_q.addr)));

    // R7: standby drops terminal count
    a_r7_standby_drops_tc: assert property (@(posedge clk) disable iff (rst_act)
        ce_n |=> !st_q.tc);

endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage (
    input  logic ce_n,
    input  logic oe_act,
    input  logic tc,
    input  logic rbit,
    output logic sdo,
    output logic sdo_en,
    output logic ceo_n
);

    logic drive_d;

    always_comb begin
        drive_d = !ce_n && oe_act && !tc;
        sdo_en  = drive_d;
        sdo     = drive_d & rbit;
        ceo_n   = !tc;
    end

    // R4/R5: no drive unless both enables are active
    always_comb begin
        if (ce_n || !oe_act) begin
            a_r4_r5_float: assert (!sdo_en && !sdo);
        end
    end

endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom
    import cfg_rom_pkg::*;
#(
    parameter int DEPTH           = 256,
    parameter bit RST_ACTIVE_HIGH = 1'b0,
    parameter int ADDR_W          = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              ce_n,
    input  logic              rst_oe,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_bit,
    output logic              sdo,
    output logic              sdo_en,
    output logic              ceo_n
);

    logic              rst_act;
    logic              oe_act;
    logic [ADDR_W-1:0] rd_addr;
    logic              tc;
    logic              rd_bit;

    // R3: polarity variant picked by parameter
    generate
        if (RST_ACTIVE_HIGH) begin : g_rst_high
            assign rst_act = rst_oe;
        end else begin : g_rst_low
            assign rst_act = !rst_oe;
        end
    endgenerate

    assign oe_act = pin_enables(rst_oe, RST_ACTIVE_HIGH);

    cfg_bit_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (ld_we),
        .waddr (ld_addr),
        .wbit  (ld_bit),
        .raddr (rd_addr),
        .rbit  (rd_bit)
    );

    cfg_addr_ctr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctr (
        .clk     (clk),
        .rst_act (rst_act),
        .ce_n    (ce_n),
        .addr    (rd_addr),
        .tc      (tc)
    );

    cfg_out_stage u_out (
        .ce_n   (ce_n),
        .oe_act (oe_act),
        .tc     (tc),
        .rbit   (rd_bit),
        .sdo    (sdo),
        .sdo_en (sdo_en),
        .ceo_n  (ceo_n)
    );

    // R6/R8: once the cascade output is low this device releases the line
    a_r8_release_on_cascade: assert property (@(posedge clk) disable iff (rst_act)
        !ceo_n |-> !sdo_en);

    // R7: reset-level edge raises the cascade output
    a_r7_reset_raises_ceo: assert property (@(posedge clk)
        rst_act |=> ceo_n);

endmodule

// File: tb/test_serial_cfg_rom.sv
module test_serial_cfg_rom;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] PAT_A = 16'hB3C5;
    localparam logic [7:0]  PAT_B = 8'h6A;
    localparam logic [7:0]  PAT_C = 8'h95;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       a_ce_n, ab_rst, c_ce_n, c_rst;
    logic       we_a, we_b, we_c, ld_bit;
    logic [3:0] ld_addr;
    logic       a_sdo, a_en, a_ceo_n;
    logic       b_sdo, b_en, b_ceo_n;
    logic       c_sdo, c_en, c_ceo_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    serial_cfg_rom #(.DEPTH(16), .RST_ACTIVE_HIGH(1'b0)) i_serial_cfg_rom (
        .clk(clk), .ce_n(a_ce_n), .rst_oe(ab_rst), .ld_we(we_a),
        .ld_addr(ld_addr), .ld_bit(ld_bit),
        .sdo(a_sdo), .sdo_en(a_en), .ceo_n(a_ceo_n));

    serial_cfg_rom #(.DEPTH(8), .RST_ACTIVE_HIGH(1'b0)) i_serial_cfg_rom_next (
        .clk(clk), .ce_n(a_ceo_n), .rst_oe(ab_rst), .ld_we(we_b),
        .ld_addr(ld_addr[2:0]), .ld_bit(ld_bit),
        .sdo(b_sdo), .sdo_en(b_en), .ceo_n(b_ceo_n));

    serial_cfg_rom #(.DEPTH(8), .RST_ACTIVE_HIGH(1'b1)) i_serial_cfg_rom_hi (
        .clk(clk), .ce_n(c_ce_n), .rst_oe(c_rst), .ld_we(we_c),
        .ld_addr(ld_addr[2:0]), .ld_bit(ld_bit),
        .sdo(c_sdo), .sdo_en(c_en), .ceo_n(c_ceo_n));

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic reset_chain();
        ab_rst = 1'b0; c_rst = 1'b1;
        tick(); tick();
        ab_rst = 1'b1; c_rst = 1'b0;
        #1;
    endtask

    task automatic load_all();
        for (int k = 0; k < 16; k++) begin
            we_a = 1'b1; we_b = (k < 8); we_c = (k < 8);
            ld_addr = 4'(k);
            ld_bit  = PAT_A[k];
            tick();
            if (k < 8) begin
                we_a = 1'b0;
                ld_bit = PAT_B[k]; we_b = 1'b1; we_c = 1'b0;
                tick();
                ld_bit = PAT_C[k]; we_b = 1'b0; we_c = 1'b1;
                tick();
            end
        end
        we_a = 1'b0; we_b = 1'b0; we_c = 1'b0;
    endtask

    task automatic t_reset();
        ab_rst = 1'b0; c_rst = 1'b1; #1;
        check("R4 A float in reset", a_en, 1'b0);
        check("R4 A data zero in reset", a_sdo, 1'b0);
        tick();
        check("R1 A ceo_n high after reset", a_ceo_n, 1'b1);
        check("R4 C float in reset", c_en, 1'b0);
        ab_rst = 1'b1; c_rst = 1'b0; #1;
        check("R1 A drives after release", a_en, 1'b1);
        check("R1 A bit0", a_sdo, PAT_A[0]);
        check("R8 B idle while A runs", b_en, 1'b0);
    endtask

    task automatic t_stream();
        reset_chain();
        for (int i = 1; i < 16; i++) begin
            tick();
            check($sformatf("R2 A bit %0d", i), a_sdo, PAT_A[i]);
            check("R2 A drive", a_en, 1'b1);
            check("R8 B quiet", b_en, 1'b0);
        end
        tick();
        check("R6 A ceo_n low at end", a_ceo_n, 1'b0);
        check("R6 A released", a_en, 1'b0);
        check("R8 B takes over", b_en, 1'b1);
        check("R8 B bit0", b_sdo, PAT_B[0]);
        for (int i = 1; i < 8; i++) begin
            tick();
            check($sformatf("R8 B bit %0d", i), b_sdo, PAT_B[i]);
            check("R8 one driver", 1'(a_en & b_en), 1'b0);
            check("R6 A stays parked", a_ceo_n, 1'b0);
        end
        tick();
        check("R6 B ceo_n low", b_ceo_n, 1'b0);
        check("R6 B released", b_en, 1'b0);
    endtask

    task automatic t_standby();
        reset_chain();
        tick(); tick(); tick();
        check("R2 A at bit3", a_sdo, PAT_A[3]);
        a_ce_n = 1'b1; #1;
        check("R5 float in standby", a_en, 1'b0);
        tick();
        ab_rst = 1'b1; #1;
        check("R5 float with oe active", a_en, 1'b0);
        tick(); tick();
        a_ce_n = 1'b0; #1;
        check("R5 resumes same bit", a_sdo, PAT_A[3]);
        check("R5 drives again", a_en, 1'b1);
        for (int i = 4; i < 16; i++) tick();
        tick();
        check("R6 ceo_n low", a_ceo_n, 1'b0);
        a_ce_n = 1'b1;
        tick();
        check("R7 standby raises ceo_n", a_ceo_n, 1'b1);
        a_ce_n = 1'b0;
    endtask

    task automatic t_reset_mid();
        reset_chain();
        for (int i = 0; i < 16; i++) tick();
        check("R6 at end", a_ceo_n, 1'b0);
        ab_rst = 1'b0; #1;
        check("R4 float on reset", a_en, 1'b0);
        tick();
        check("R7 reset raises ceo_n", a_ceo_n, 1'b1);
        ab_rst = 1'b1; #1;
        check("R1 restart bit0", a_sdo, PAT_A[0]);
        tick();
        check("R1 restart bit1", a_sdo, PAT_A[1]);
    endtask

    task automatic t_polarity();
        reset_chain();
        check("R3 C runs with pin low", c_en, 1'b1);
        check("R3 C bit0", c_sdo, PAT_C[0]);
        tick(); tick();
        check("R3 C bit2", c_sdo, PAT_C[2]);
        c_rst = 1'b1; #1;
        check("R3 C float with pin high", c_en, 1'b0);
        tick();
        c_rst = 1'b0; #1;
        check("R3 C back to bit0", c_sdo, PAT_C[0]);
        check("R3 A runs with pin high", a_en, 1'b1);
    endtask

    task automatic t_load();
        ld_addr = 4'd0; ld_bit = ~PAT_A[0]; we_a = 1'b1;
        tick();
        we_a = 1'b0;
        reset_chain();
        check("R9 reloaded bit0", a_sdo, ~PAT_A[0]);
        tick();
        check("R9 neighbour intact", a_sdo, PAT_A[1]);
    endtask

    initial begin
        a_ce_n = 1'b0; c_ce_n = 1'b0; ab_rst = 1'b0; c_rst = 1'b1;
        we_a = 1'b0; we_b = 1'b0; we_c = 1'b0; ld_bit = 1'b0; ld_addr = '0;
        tick(); tick();
        load_all();
        t_reset();
        t_stream();
        t_standby();
        t_reset_mid();
        t_polarity();
        t_load();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule